// File: doc/BRIEF.md
# Serial Flash Parameter Discovery Unit

This block runs once after every reset and finds out what serial flash is attached behind an SPI byte engine. It drives that engine through a small command-frame port. Each frame carries an opcode, an address of up to four bytes sent most significant byte first, and the number of bytes to read back. The engine returns each read byte on a response strobe and then signals the end of the frame.

The unit first reads the three-byte manufacturer identity. If the first identity byte matches a configurable vendor code, it sends a write-enable frame and then a single-byte global unprotect frame. It then polls the status byte until the device reports that no write is in progress. The number of polls is bounded.

Next it reads the 16-byte discoverable-parameter header and checks it. From that header it takes a little-endian table pointer, which it turns into a big-endian frame address. It reads the first eight bytes of the basic parameter table and checks erase granularity and addressing mode. On success it presents the device size in bytes. Any failed check ends discovery with an error flag instead.

Top module: `flash_param_discovery`

## Requirements
- R1: The first frame after reset has opcode 0x9F, address length 0 and read length 3.
- R2: When identity byte 0 equals VENDOR_ID (default 0xBF), two frames follow the identity read, each with address length 0 and read length 0: opcode 0x06, then opcode 0x98. For any other identity byte, the next frame is the status poll.
- R3: A status poll has opcode 0x05, address length 0 and read length 1. Bit 0 of the returned byte means busy, and a busy reply causes another poll. After POLL_LIMIT busy replies in a row, the unit stops with the error flag set.
- R4: The header read has opcode 0x5A, address length 4 (three address bytes plus one dummy byte), address word 0 and read length 16.
- R5: Header bytes 0..3 must be 0x53 0x46 0x44 0x50 and header byte 5 must be 0x01. Otherwise the unit stops with the error flag set.
- R6: Header byte 8 must be 0x00 and header byte 10 must be 0x01. Otherwise the unit stops with the error flag set.
- R7: The table read has opcode 0x5A, address length 4, read length 8 and address word {hdr[14], hdr[13], hdr[12], 8'h00}. The pointer is little-endian in the header and is sent big-endian, followed by a zero dummy byte.
- R8: Table byte 0 bits 1:0 must be 2'b01 and table byte 1 must be 0x20. Otherwise the unit stops with the error flag set.
- R9: Table byte 2 bit 2 and table byte 7 bit 7 must both be 0. Otherwise the unit stops with the error flag set.
- R10: On success, `disc_ok` rises in the cycle after the table frame completes. `dev_bytes` then equals ({t7,t6,t5,t4} >> 3) + 1.
- R11: `disc_ok` and `disc_err` are never high together, and each stays high until reset. `dev_bytes` is 0 whenever `disc_ok` is low. No frame is requested once either flag is high.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the opcode, address and length fields are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; discovery restarts on release |
| cmd_valid | output | 1 | Frame request pending |
| cmd_opcode | output | 8 | Opcode byte of the requested frame |
| cmd_addr | output | 32 | Address word; the top `cmd_addr_len` bytes are sent, most significant first |
| cmd_addr_len | output | 3 | Number of address/dummy bytes (0 to 4) |
| cmd_rd_len | output | 5 | Number of bytes to read back (0 to 16) |
| cmd_ready | input | 1 | Engine accepts the frame in this cycle |
| rsp_valid | input | 1 | One read byte is present on `rsp_byte` |
| rsp_byte | input | 8 | Read data byte, in order of arrival |
| cmd_done | input | 1 | Single-cycle pulse when the accepted frame is finished |
| disc_ok | output | 1 | Discovery succeeded (sticky) |
| disc_err | output | 1 | Discovery failed (sticky) |
| dev_bytes | output | SIZE_W | Device size in bytes, 0 unless `disc_ok` |

## Verification
A wrong sequencer state shows at the frame port at the next request. The opcode, address word or lengths would differ from the frame the requirements call for in that position, so the error is caught as soon as the frame is offered. A mistake in byte capture or in the checks shows one cycle after the last frame completes, as the wrong flag or a wrong size. Because the flags are sticky and no frame may follow them, a state that leaves the end states would show as an extra request within a cycle.

// File: rtl/flash_disc_pkg.sv
package flash_disc_pkg;

   localparam logic [7:0] OP_IDENT   = 8'h9F;
   localparam logic [7:0] OP_WR_EN   = 8'h06;
   localparam logic [7:0] OP_UNLOCK  = 8'h98;
   localparam logic [7:0] OP_STATUS  = 8'h05;
   localparam logic [7:0] OP_PARAM   = 8'h5A;

   localparam int HDR_BYTES  = 16;
   localparam int TBL_BYTES  = 8;
   localparam int IDENT_LEN  = 3;
   localparam int PARAM_ALEN = 4;

   typedef enum logic [3:0] {
      ST_IDENT_REQ,
      ST_IDENT_WAIT,
      ST_WREN_REQ,
      ST_WREN_WAIT,
      ST_UNLK_REQ,
      ST_UNLK_WAIT,
      ST_POLL_REQ,
      ST_POLL_WAIT,
      ST_HDR_REQ,
      ST_HDR_WAIT,
      ST_TBL_REQ,
      ST_TBL_WAIT,
      ST_FINISH_OK,
      ST_FINISH_ERR
   } disc_state_t;

endpackage

// File: rtl/fd_byte_capture.sv
module fd_byte_capture #(
   parameter int DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               wr_en,
   input  logic [7:0]         wr_byte,
   output logic [DEPTH*8-1:0] bytes_flat
);

   localparam int IDX_W = $clog2(DEPTH + 1);

   logic [IDX_W-1:0] idx_q;
   logic             room;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("fd_byte_capture: DEPTH must be at least 1");
      end
   endgenerate

   assign room = (idx_q < IDX_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear) begin
         idx_q <= '0;
      end else if (wr_en && room) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [7:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '0;
            end else if (wr_en && !clear && (idx_q == IDX_W'(g))) begin
               slot_q <= wr_byte;
            end
         end
         assign bytes_flat[8*g +: 8] = slot_q;
      end
   endgenerate

   // Engine must never return more bytes than the frame asked for (R4, R7)
   p_no_overflow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear) |-> room);

   p_index_moves_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear && room) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/fd_param_check.sv
module fd_param_check #(
   parameter int SIZE_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic [DEPTH*8-1:0] bytes_flat,
   output logic               hdr_ok,
   output logic               tbl_ok,
   output logic [23:0]        tbl_ptr,
   output logic [SIZE_W-1:0]  byte_count
);

   localparam int CNT_W = 29;

   logic [7:0]       b [DEPTH];
   logic             sig_ok;
   logic             ver_ok;
   logic             first_hdr_ok;
   logic             erase_ok;
   logic             addr_ok;
   logic [31:0]      density;
   logic [CNT_W-1:0] count_raw;

   generate
      if (DEPTH < 16) begin : g_bad_depth
         $error("fd_param_check: DEPTH must cover the 16-byte header");
      end
      if (SIZE_W < CNT_W) begin : g_bad_size
         $error("fd_param_check: SIZE_W must be at least 29");
      end
      for (genvar k = 0; k < DEPTH; k++) begin : g_unpack
         assign b[k] = bytes_flat[8*k +: 8];
      end
   endgenerate

   // Header checks: signature, major revision, first parameter header
   assign sig_ok       = (b[0] == 8'h53) && (b[1] == 8'h46) &&
                         (b[2] == 8'h44) && (b[3] == 8'h50);
   assign ver_ok       = (b[5] == 8'h01);
   assign first_hdr_ok = (b[8] == 8'h00) && (b[10] == 8'h01);
   assign hdr_ok       = sig_ok && ver_ok && first_hdr_ok;

   // Pointer arrives least significant byte first
   assign tbl_ptr = {b[14], b[13], b[12]};

   // Table checks: 4 KiB erase with the expected opcode, 3-byte addressing
   assign erase_ok = (b[0][1:0] == 2'b01) && (b[1] == 8'h20);
   assign addr_ok  = !b[2][2] && !b[7][7];
   assign tbl_ok   = erase_ok && addr_ok;

   // Density is bits minus one, little-endian
   assign density   = {b[7], b[6], b[5], b[4]};
   assign count_raw = density[31:3] + CNT_W'(1);

   generate
      if (SIZE_W > CNT_W) begin : g_pad
         assign byte_count = {{(SIZE_W-CNT_W){1'b0}}, count_raw};
      end else begin : g_exact
         assign byte_count = count_raw;
      end
   endgenerate

   logic unused_hdr_bytes;
   assign unused_hdr_bytes = ^{b[4], b[9], b[11], b[15], b[3], density[2:0]};

endmodule

// File: rtl/fd_sequencer.sv
module fd_sequencer
   import flash_disc_pkg::*;
#(
   parameter int          POLL_LIMIT  = 1000,
   parameter bit          UNLOCK_EN   = 1'b1,
   parameter logic [7:0]  VENDOR_ID   = 8'hBF,
   parameter int          SIZE_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cmd_valid,
   output logic [7:0]        cmd_opcode,
   output logic [31:0]       cmd_addr,
   output logic [2:0]        cmd_addr_len,
   output logic [4:0]        cmd_rd_len,
   input  logic              cmd_ready,
   input  logic              cmd_done,
   input  logic [7:0]        first_byte,
   input  logic              hdr_ok,
   input  logic              tbl_ok,
   input  logic [23:0]       tbl_ptr,
   input  logic [SIZE_W-1:0] byte_count,
   output logic              cap_en,
   output logic              cap_clear,
   output logic              disc_ok,
   output logic              disc_err,
   output logic [SIZE_W-1:0] dev_bytes
);

   localparam int POLL_W = $clog2(POLL_LIMIT + 1);

   disc_state_t       state_q, state_d;
   logic [POLL_W-1:0] poll_q, poll_d;
   logic              ok_q, ok_d;
   logic              err_q, err_d;
   logic [SIZE_W-1:0] size_q, size_d;
   logic              want_unlock;
   logic              accept;
   logic              in_wait;

   generate
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("fd_sequencer: POLL_LIMIT must be at least 1");
      end
      if (UNLOCK_EN) begin : g_unlock
         assign want_unlock = (first_byte == VENDOR_ID);
      end else begin : g_no_unlock
         logic unused_first;
         assign unused_first = ^first_byte;
         assign want_unlock  = 1'b0;
      end
   endgenerate

   // Frame fields, decoded from the request states only
   always_comb begin
      cmd_valid    = 1'b0;
      cmd_opcode   = 8'h00;
      cmd_addr     = 32'h0;
      cmd_addr_len = 3'd0;
      cmd_rd_len   = 5'd0;
      unique case (state_q)
         ST_IDENT_REQ: begin
            cmd_valid  = 1'b1;
            cmd_opcode = OP_IDENT;
            cmd_rd_len = 5'(IDENT_LEN);
         end
         ST_WREN_REQ: begin
            cmd_valid  = 1'b1;
            cmd_opcode = OP_WR_EN;
         end
         ST_UNLK_REQ: begin
            cmd_valid  = 1'b1;
            cmd_opcode = OP_UNLOCK;
         end
         ST_POLL_REQ: begin
            cmd_valid  = 1'b1;
            cmd_opcode = OP_STATUS;
            cmd_rd_len = 5'd1;
         end
         ST_HDR_REQ: begin
            cmd_valid    = 1'b1;
            cmd_opcode   = OP_PARAM;
            cmd_addr_len = 3'(PARAM_ALEN);
            cmd_rd_len   = 5'(HDR_BYTES);
         end
         ST_TBL_REQ: begin
            cmd_valid    = 1'b1;
            cmd_opcode   = OP_PARAM;
            cmd_addr     = {tbl_ptr, 8'h00};
            cmd_addr_len = 3'(PARAM_ALEN);
            cmd_rd_len   = 5'(TBL_BYTES);
         end
         default: ;
      endcase
   end

   assign accept    = cmd_valid && cmd_ready;
   assign in_wait   = (state_q == ST_IDENT_WAIT) || (state_q == ST_WREN_WAIT) ||
                      (state_q == ST_UNLK_WAIT)  || (state_q == ST_POLL_WAIT) ||
                      (state_q == ST_HDR_WAIT)   || (state_q == ST_TBL_WAIT);
   assign cap_en    = in_wait;
   assign cap_clear = accept;

   always_comb begin
      state_d = state_q;
      poll_d  = poll_q;
      ok_d    = ok_q;
      err_d   = err_q;
      size_d  = size_q;
      unique case (state_q)
         ST_IDENT_REQ:  if (accept) state_d = ST_IDENT_WAIT;
         ST_IDENT_WAIT: if (cmd_done) state_d = want_unlock ? ST_WREN_REQ : ST_POLL_REQ;
         ST_WREN_REQ:   if (accept) state_d = ST_WREN_WAIT;
         ST_WREN_WAIT:  if (cmd_done) state_d = ST_UNLK_REQ;
         ST_UNLK_REQ:   if (accept) state_d = ST_UNLK_WAIT;
         ST_UNLK_WAIT:  if (cmd_done) state_d = ST_POLL_REQ;
         ST_POLL_REQ:   if (accept) state_d = ST_POLL_WAIT;
         ST_POLL_WAIT: begin
            if (cmd_done) begin
               if (!first_byte[0]) begin
                  state_d = ST_HDR_REQ;
                  poll_d  = '0;
               end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
                  state_d = ST_FINISH_ERR;
                  err_d   = 1'b1;
               end else begin
                  state_d = ST_POLL_REQ;
                  poll_d  = poll_q + 1'b1;
               end
            end
         end
         ST_HDR_REQ:    if (accept) state_d = ST_HDR_WAIT;
         ST_HDR_WAIT: begin
            if (cmd_done) begin
               if (hdr_ok) begin
                  state_d = ST_TBL_REQ;
               end else begin
                  state_d = ST_FINISH_ERR;
                  err_d   = 1'b1;
               end
            end
         end
         ST_TBL_REQ:    if (accept) state_d = ST_TBL_WAIT;
         ST_TBL_WAIT: begin
            if (cmd_done) begin
               if (tbl_ok) begin
                  state_d = ST_FINISH_OK;
                  ok_d    = 1'b1;
                  size_d  = byte_count;
               end else begin
                  state_d = ST_FINISH_ERR;
                  err_d   = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDENT_REQ;
         poll_q  <= '0;
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         size_q  <= '0;
      end else begin
         state_q <= state_d;
         poll_q  <= poll_d;
         ok_q    <= ok_d;
         err_q   <= err_d;
         size_q  <= size_d;
      end
   end

   assign disc_ok   = ok_q;
   assign disc_err  = err_q;
   assign dev_bytes = size_q;

   p_flags_excl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !(disc_ok && disc_err));

   p_ok_sticky_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      disc_ok |=> disc_ok);

   p_err_sticky_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      disc_err |=> disc_err);

   p_size_gated_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !disc_ok |-> (dev_bytes == '0));

   p_quiet_after_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (disc_ok || disc_err) |-> !cmd_valid);

   p_hold_frame_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) &&
         $stable(cmd_addr) && $stable(cmd_addr_len) && $stable(cmd_rd_len)));

   p_poll_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      poll_q < POLL_W'(POLL_LIMIT));

   p_size_on_success_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disc_ok) |-> (dev_bytes != '0));

endmodule

// File: rtl/flash_param_discovery.sv
module flash_param_discovery
   import flash_disc_pkg::*;
#(
   parameter int         POLL_LIMIT = 1000,
   parameter bit         UNLOCK_EN  = 1'b1,
   parameter logic [7:0] VENDOR_ID  = 8'hBF,
   parameter int         SIZE_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cmd_valid,
   output logic [7:0]        cmd_opcode,
   output logic [31:0]       cmd_addr,
   output logic [2:0]        cmd_addr_len,
   output logic [4:0]        cmd_rd_len,
   input  logic              cmd_ready,
   input  logic              rsp_valid,
   input  logic [7:0]        rsp_byte,
   input  logic              cmd_done,
   output logic              disc_ok,
   output logic              disc_err,
   output logic [SIZE_W-1:0] dev_bytes
);

   localparam int BUF_DEPTH = HDR_BYTES;

   logic [BUF_DEPTH*8-1:0] cap_bytes;
   logic                   cap_en;
   logic                   cap_clear;
   logic                   hdr_ok;
   logic                   tbl_ok;
   logic [23:0]            tbl_ptr;
   logic [SIZE_W-1:0]      byte_count;

   fd_byte_capture #(
      .DEPTH (BUF_DEPTH)
   ) i_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cap_clear),
      .wr_en      (rsp_valid && cap_en),
      .wr_byte    (rsp_byte),
      .bytes_flat (cap_bytes)
   );

   fd_param_check #(
      .SIZE_W (SIZE_W),
      .DEPTH  (BUF_DEPTH)
   ) i_check (
      .bytes_flat (cap_bytes),
      .hdr_ok     (hdr_ok),
      .tbl_ok     (tbl_ok),
      .tbl_ptr    (tbl_ptr),
      .byte_count (byte_count)
   );

   fd_sequencer #(
      .POLL_LIMIT (POLL_LIMIT),
      .UNLOCK_EN  (UNLOCK_EN),
      .VENDOR_ID  (VENDOR_ID),
      .SIZE_W     (SIZE_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_opcode   (cmd_opcode),
      .cmd_addr     (cmd_addr),
      .cmd_addr_len (cmd_addr_len),
      .cmd_rd_len   (cmd_rd_len),
      .cmd_ready    (cmd_ready),
      .cmd_done     (cmd_done),
      .first_byte   (cap_bytes[7:0]),
      .hdr_ok       (hdr_ok),
      .tbl_ok       (tbl_ok),
      .tbl_ptr      (tbl_ptr),
      .byte_count   (byte_count),
      .cap_en       (cap_en),
      .cap_clear    (cap_clear),
      .disc_ok      (disc_ok),
      .disc_err     (disc_err),
      .dev_bytes    (dev_bytes)
   );

endmodule

// File: tb/test_flash_param_discovery.sv
module test_flash_param_discovery;

   localparam int LIMIT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid;
   logic [7:0]  cmd_opcode;
   logic [31:0] cmd_addr;
   logic [2:0]  cmd_addr_len;
   logic [4:0]  cmd_rd_len;
   logic        cmd_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [7:0]  rsp_byte = 8'h00;
   logic        cmd_done = 1'b0;
   logic        disc_ok;
   logic        disc_err;
   logic [31:0] dev_bytes;

   int compared = 0;
   int mismatched = 0;

   // Behavioural flash contents for the current scenario
   logic [7:0] id0;
   logic [7:0] hdr [16];
   logic [7:0] tbl [8];
   int         busy_n;
   int         polls_seen;

   // Expected frame sequence and outcome
   logic [7:0]  q_op [$];
   logic [2:0]  q_alen [$];
   logic [31:0] q_addr [$];
   logic [4:0]  q_rlen [$];
   string       q_tag [$];
   logic        exp_ok, exp_err;
   logic [31:0] exp_size;
   logic        final_on = 1'b0;

   always #10 clk = ~clk;

   flash_param_discovery #(
      .POLL_LIMIT (LIMIT),
      .SIZE_W     (32)
   ) i_flash_param_discovery (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_opcode   (cmd_opcode),
      .cmd_addr     (cmd_addr),
      .cmd_addr_len (cmd_addr_len),
      .cmd_rd_len   (cmd_rd_len),
      .cmd_ready    (cmd_ready),
      .rsp_valid    (rsp_valid),
      .rsp_byte     (rsp_byte),
      .cmd_done     (cmd_done),
      .disc_ok      (disc_ok),
      .disc_err     (disc_err),
      .dev_bytes    (dev_bytes)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model of the outcome, written from the requirements
   task automatic build_expectation();
      logic bad;
      q_op.delete(); q_alen.delete(); q_addr.delete(); q_rlen.delete(); q_tag.delete();
      exp_ok = 1'b0; exp_err = 1'b0; exp_size = 32'h0;
      q_op.push_back(8'h9F); q_alen.push_back(3'd0); q_addr.push_back(0); q_rlen.push_back(5'd3); q_tag.push_back("R1");
      if (id0 == 8'hBF) begin
         q_op.push_back(8'h06); q_alen.push_back(3'd0); q_addr.push_back(0); q_rlen.push_back(5'd0); q_tag.push_back("R2");
         q_op.push_back(8'h98); q_alen.push_back(3'd0); q_addr.push_back(0); q_rlen.push_back(5'd0); q_tag.push_back("R2");
      end
      for (int i = 0; i < LIMIT; i++) begin
         q_op.push_back(8'h05); q_alen.push_back(3'd0); q_addr.push_back(0); q_rlen.push_back(5'd1); q_tag.push_back("R3");
         if (i >= busy_n) break;
      end
      if (busy_n >= LIMIT) begin
         exp_err = 1'b1;
         return;
      end
      q_op.push_back(8'h5A); q_alen.push_back(3'd4); q_addr.push_back(0); q_rlen.push_back(5'd16); q_tag.push_back("R4");
      bad = !(hdr[0] == "S" && hdr[1] == "F" && hdr[2] == "D" && hdr[3] == "P" && hdr[5] == 8'd1)
            || !(hdr[8] == 8'd0 && hdr[10] == 8'd1);
      if (bad) begin
         exp_err = 1'b1;
         return;
      end
      q_op.push_back(8'h5A); q_alen.push_back(3'd4); q_addr.push_back({hdr[14], hdr[13], hdr[12], 8'h00});
      q_rlen.push_back(5'd8); q_tag.push_back("R7");
      bad = ((tbl[0] & 8'h03) != 8'h01) || (tbl[1] != 8'h20) || tbl[2][2] || tbl[7][7];
      if (bad) begin
         exp_err = 1'b1;
         return;
      end
      exp_ok   = 1'b1;
      exp_size = ({tbl[7], tbl[6], tbl[5], tbl[4]} / 8) + 1;
   endtask

   // Byte engine plus flash responder
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cmd_valid) begin
            logic [7:0]  op;
            logic [31:0] ad;
            logic [2:0]  al;
            logic [4:0]  rl;
            logic [7:0]  data;
            op = cmd_opcode; ad = cmd_addr; al = cmd_addr_len; rl = cmd_rd_len;
            if (q_op.size() == 0) begin
               check("R11 unexpected frame", {24'h0, op}, 32'h0);
            end else begin
               check({q_tag[0], " opcode"}, {24'h0, op}, {24'h0, q_op[0]});
               check({q_tag[0], " addr_len"}, {29'h0, al}, {29'h0, q_alen[0]});
               check({q_tag[0], " addr"}, ad, q_addr[0]);
               check({q_tag[0], " rd_len"}, {27'h0, rl}, {27'h0, q_rlen[0]});
               void'(q_op.pop_front()); void'(q_alen.pop_front()); void'(q_addr.pop_front());
               void'(q_rlen.pop_front()); void'(q_tag.pop_front());
            end
            @(negedge clk);
            // R12: fields held while not accepted
            check("R12 hold valid", {31'h0, cmd_valid}, 32'h1);
            check("R12 hold opcode", {24'h0, cmd_opcode}, {24'h0, op});
            check("R12 hold addr", cmd_addr, ad);
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            for (int i = 0; i < int'(rl); i++) begin
               case (op)
                  8'h9F: data = (i == 0) ? id0 : 8'h20 + 8'(i);
                  8'h05: begin
                     data = (polls_seen < busy_n) ? 8'h03 : 8'h02;
                     polls_seen++;
                  end
                  8'h5A: data = (ad == 0) ? hdr[i] : tbl[i];
                  default: data = 8'hFF;
               endcase
               rsp_valid = 1'b1;
               rsp_byte  = data;
               @(negedge clk);
            end
            rsp_valid = 1'b0;
            cmd_done  = 1'b1;
            if (q_op.size() == 0) final_on = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
         end
      end
   end

   // Per-clock comparison of the outcome ports (R10, R11)
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n) begin
            if (final_on) begin
               check("R10/R11 ok flag", {31'h0, disc_ok}, {31'h0, exp_ok});
               check("R11 err flag", {31'h0, disc_err}, {31'h0, exp_err});
               check("R10 dev_bytes", dev_bytes, exp_size);
               check("R11 quiet", {31'h0, cmd_valid}, 32'h0);
            end else begin
               check("R11 ok low", {31'h0, disc_ok}, 32'h0);
               check("R11 err low", {31'h0, disc_err}, 32'h0);
               check("R11 size zero", dev_bytes, 32'h0);
            end
         end
      end
   end

   task automatic good_device(input logic [7:0] vid, input logic [23:0] ptr, input logic [31:0] dens);
      id0 = vid;
      busy_n = 0;
      hdr[0] = "S"; hdr[1] = "F"; hdr[2] = "D"; hdr[3] = "P";
      hdr[4] = 8'h06; hdr[5] = 8'h01; hdr[6] = 8'h00; hdr[7] = 8'hFF;
      hdr[8] = 8'h00; hdr[9] = 8'h06; hdr[10] = 8'h01; hdr[11] = 8'h09;
      hdr[12] = ptr[7:0]; hdr[13] = ptr[15:8]; hdr[14] = ptr[23:16]; hdr[15] = 8'hFF;
      tbl[0] = 8'hE5; tbl[1] = 8'h20; tbl[2] = 8'hF1; tbl[3] = 8'hFF;
      tbl[4] = dens[7:0]; tbl[5] = dens[15:8]; tbl[6] = dens[23:16]; tbl[7] = dens[31:24];
   endtask

   task automatic run(input string name);
      rst_n = 1'b0;
      final_on = 1'b0;
      polls_seen = 0;
      build_expectation();
      repeat (3) @(negedge clk);
      // reset state
      check({name, " R11 reset ok"}, {31'h0, disc_ok}, 32'h0);
      check({name, " R11 reset err"}, {31'h0, disc_err}, 32'h0);
      rst_n = 1'b1;
      for (int c = 0; c < 2000 && !final_on; c++) @(negedge clk);
      repeat (6) @(negedge clk);
      check({name, " all frames seen"}, q_op.size(), 0);
   endtask

   initial begin
      #(20 * 150000);
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1 R3 R4 R7 R10: ordinary device, 8 Mbit
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      run("plain");
      // R2 R3 R10: unlock path, two busy polls, large pointer, 256 Mbit
      good_device(8'hBF, 24'h012345, 32'h0FFFFFFF);
      busy_n = 2;
      run("unlock");
      // R3: busy through the last allowed poll
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      busy_n = LIMIT - 1;
      run("late idle");
      // R3: never idle
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      busy_n = LIMIT;
      run("timeout");
      // R5: bad signature
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      hdr[2] = "X";
      run("bad sig");
      // R5: wrong major revision
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      hdr[5] = 8'h02;
      run("bad rev");
      // R6: first parameter header not basic table
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      hdr[10] = 8'h02;
      run("bad phdr");
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      hdr[8] = 8'h01;
      run("bad id");
      // R8: erase opcode mismatch, then granularity bits
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      tbl[1] = 8'hD8;
      run("bad erase op");
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      tbl[0] = 8'hE6;
      run("bad erase gran");
      // R9: 4-byte addressing, then indirect density
      good_device(8'hC2, 24'h000030, 32'h007FFFFF);
      tbl[2] = 8'hF5;
      run("addr4");
      good_device(8'hC2, 24'h000030, 32'h80000021);
      run("dens hi");
      // R10: smallest density value
      good_device(8'h20, 24'h000080, 32'h00000007);
      run("tiny");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule